// File: doc/BRIEF.md
# E3 Transmit Payload Interface

This block sits between system-side equipment and an E3 transmit framer. It takes in outbound payload data either one bit at a time or four bits at a time. It turns that data into a single payload bit stream and tags every bit with its position inside the 1536-bit E3 frame. The block runs on one processing clock. The bit-rate timing arrives as one-cycle tick strobes. One strobe is derived from the recovered receive line clock (loop timing). The other comes from a locally supplied line-rate clock (local timing). The selected timing is driven back to the system side as `sys_tick_o`. In nibble mode this output pulses once per four bit periods, which gives the quarter-rate nibble clock.

A 3-bit mode code sets the data width, the timing source and the frame alignment. In two modes the alignment follows a frame-reference input. In the others the counter runs freely from reset. In every mode the system side sees one frame pulse per frame, and it lasts for the bit or nibble period that carries the last frame bit.

Top module: `e3_tx_payload_if`

## Requirements
- R1: While `rst_ni` is low, `bit_vld_o`, `frame_pulse_o` and `bit_pos_o` are all 0.
- R2: Mode codes 1–3 are serial and 4–6 are nibble. Codes 1 and 4 are timed by `rec_tick_i`. Codes 2, 3, 5 and 6 are timed by `loc_tick_i`. Codes 0 and 7 act as code 1. A pulse on the tick line that is not selected has no effect on any output.
- R3: In serial mode, each selected tick captures `ser_i`. One clock later, `bit_vld_o` is high for one cycle, with that bit on `bit_o` and its position on `bit_pos_o`. Positions run 0 to 1535 and then wrap to 0.
- R4: In nibble mode, `sys_tick_o` pulses on every fourth selected tick and captures `nib_i` at that tick. On each of the next four selected ticks, one bit leaves the block, `nib_i[3]` first. The bits carry consecutive positions that start at a multiple of 4.
- R5: In serial mode, `sys_tick_o` equals the selected tick.
- R6: `frame_pulse_o` is high exactly while the next unit to be taken holds bit 1535. In serial mode that unit is position 1535. In nibble mode it is the nibble that starts at position 1532. This gives one bit period (or one nibble period) of pulse in every 1536 bits.
- R7: In modes 2 and 5, a rising edge on `frame_ref_i` in a cycle with no selected tick makes the next unit start at position 0. It also restarts the nibble phase, so the next nibble is captured on the fourth tick after the edge.
- R8: In modes 1, 3, 4 and 6, `frame_ref_i` has no effect. Alignment starts at position 0 after reset.
- R9: `mode_i` is captured on the first clock after reset is released. Ticks in that cycle are not counted. Later changes to `mode_i` have no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processing clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Mode code, captured after reset |
| rec_tick_i | input | 1 | Bit strobe from the recovered line clock |
| loc_tick_i | input | 1 | Bit strobe from the local line-rate clock |
| frame_ref_i | input | 1 | Frame reference; a rising edge realigns |
| ser_i | input | 1 | Serial payload bit |
| nib_i | input | 4 | Nibble payload, bit 3 first on the wire |
| sys_tick_o | output | 1 | Bit or nibble clock strobe to the system side |
| frame_pulse_o | output | 1 | Last-bit-of-frame marker |
| bit_o | output | 1 | Payload bit to the framer |
| bit_vld_o | output | 1 | `bit_o` valid for one cycle |
| bit_pos_o | output | 11 | Frame position of `bit_o` |

## Verification
The assertions assume that no two selected ticks arrive closer together than the emitter can drain them. They also assume that a reference edge never falls in the same cycle as a selected tick. Under those conditions, the nibble shifter never holds more than one bit when a new nibble is loaded, and the counter cannot wrap while it is being realigned. To stay within these limits, the stimulus uses one selected tick every other cycle. It puts the unused tick line and the reference edge only in the idle cycles between selected ticks.

// File: rtl/e3_txp_pkg.sv
package e3_txp_pkg;

  typedef struct packed {
    logic nibble;    // four bits per unit
    logic loop_t;    // timed from recovered line clock
    logic ref_lock;  // alignment follows frame reference
  } mode_cfg_t;

  function automatic mode_cfg_t decode_mode(input logic [2:0] code);
    mode_cfg_t c;
    case (code)
      3'd2:    c = '{nibble: 1'b0, loop_t: 1'b0, ref_lock: 1'b1};
      3'd3:    c = '{nibble: 1'b0, loop_t: 1'b0, ref_lock: 1'b0};
      3'd4:    c = '{nibble: 1'b1, loop_t: 1'b1, ref_lock: 1'b0};
      3'd5:    c = '{nibble: 1'b1, loop_t: 1'b0, ref_lock: 1'b1};
      3'd6:    c = '{nibble: 1'b1, loop_t: 1'b0, ref_lock: 1'b0};
      default: c = '{nibble: 1'b0, loop_t: 1'b1, ref_lock: 1'b0};
    endcase
    return c;
  endfunction

endpackage

// File: rtl/e3_txp_mode_ctrl.sv
module e3_txp_mode_ctrl
  import e3_txp_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic [2:0] mode_i,
  input  logic      rec_tick_i,
  input  logic      loc_tick_i,
  input  logic      frame_ref_i,
  output mode_cfg_t cfg_o,
  output logic      bit_tick_o,
  output logic      ref_edge_o
);

  logic      cfg_done_q;
  mode_cfg_t cfg_q;
  logic      ref_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_done_q <= 1'b0;
      cfg_q      <= decode_mode(3'd1);
      ref_q      <= 1'b0;
    end else begin
      ref_q <= frame_ref_i;
      if (!cfg_done_q) begin
        cfg_done_q <= 1'b1;
        cfg_q      <= decode_mode(mode_i);
      end
    end
  end

  always_comb begin
    cfg_o      = cfg_q;
    bit_tick_o = cfg_done_q && (cfg_q.loop_t ? rec_tick_i : loc_tick_i);
    ref_edge_o = cfg_done_q && cfg_q.ref_lock && frame_ref_i && !ref_q;
  end

  AST_MODE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_done_q |=> $stable(cfg_q)); // R9

endmodule

// File: rtl/e3_txp_frame_ctr.sv
module e3_txp_frame_ctr #(
  parameter int FRAME_BITS = 1536,
  parameter int NIB_W      = 4,
  parameter int POS_W      = $clog2(FRAME_BITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             nibble_i,
  input  logic             bit_tick_i,
  input  logic             realign_i,
  output logic             nib_tick_o,
  output logic             unit_take_o,
  output logic [POS_W-1:0] unit_pos_o,
  output logic             frame_pulse_o
);

  localparam int PH_W = (NIB_W > 1) ? $clog2(NIB_W) : 1;
  localparam logic [POS_W-1:0] LAST_SER = POS_W'(FRAME_BITS - 1);
  localparam logic [POS_W-1:0] LAST_NIB = POS_W'(FRAME_BITS - NIB_W);
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(NIB_W - 1);

  logic [POS_W-1:0] cnt_q, pos_now;
  logic [PH_W-1:0]  ph_q, ph_now;
  logic [POS_W:0]   pos_sum;

  always_comb begin
    pos_now       = realign_i ? '0 : cnt_q;
    ph_now        = realign_i ? '0 : ph_q;
    nib_tick_o    = bit_tick_i && (ph_now == PH_LAST);
    unit_take_o   = nibble_i ? nib_tick_o : bit_tick_i;
    unit_pos_o    = pos_now;
    pos_sum       = {1'b0, pos_now} + (nibble_i ? (POS_W+1)'(NIB_W) : (POS_W+1)'(1));
    frame_pulse_o = (cnt_q == (nibble_i ? LAST_NIB : LAST_SER));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ph_q  <= '0;
    end else begin
      if (unit_take_o)
        cnt_q <= (pos_sum >= (POS_W+1)'(FRAME_BITS)) ? '0 : pos_sum[POS_W-1:0];
      else
        cnt_q <= pos_now;
      if (bit_tick_i)
        ph_q <= (ph_now == PH_LAST) ? '0 : ph_now + 1'b1;
      else
        ph_q <= ph_now;
    end
  end

  AST_POS_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < POS_W'(FRAME_BITS)); // R3
  AST_NIB_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nibble_i |-> (int'(cnt_q) % NIB_W) == 0); // R4
  AST_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unit_take_o && !realign_i && frame_pulse_o |=> cnt_q == '0); // R6
  AST_PULSE_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_pulse_o && unit_take_o |=> !frame_pulse_o); // R6
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_tick_i && !realign_i |=> $stable(cnt_q)); // R2
  AST_REALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    realign_i && !bit_tick_i |=> cnt_q == '0 && ph_q == '0); // R7

endmodule

// File: rtl/e3_txp_serializer.sv
module e3_txp_serializer #(
  parameter int NIB_W = 4,
  parameter int POS_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             nibble_i,
  input  logic             bit_tick_i,
  input  logic             take_i,
  input  logic [POS_W-1:0] take_pos_i,
  input  logic             ser_i,
  input  logic [NIB_W-1:0] nib_i,
  output logic             bit_o,
  output logic             bit_vld_o,
  output logic [POS_W-1:0] bit_pos_o
);

  localparam int CW = $clog2(NIB_W + 1);

  logic [NIB_W-1:0] sh_q;
  logic [CW-1:0]    sh_cnt_q;
  logic [POS_W-1:0] sh_pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q      <= '0;
      sh_cnt_q  <= '0;
      sh_pos_q  <= '0;
      bit_o     <= 1'b0;
      bit_vld_o <= 1'b0;
      bit_pos_o <= '0;
    end else begin
      bit_vld_o <= 1'b0;
      if (!nibble_i) begin
        if (take_i) begin
          bit_o     <= ser_i;
          bit_pos_o <= take_pos_i;
          bit_vld_o <= 1'b1;
        end
      end else begin
        if (bit_tick_i && sh_cnt_q != '0) begin
          bit_o     <= sh_q[NIB_W-1];
          bit_pos_o <= sh_pos_q;
          bit_vld_o <= 1'b1;
          sh_q      <= sh_q << 1;
          sh_cnt_q  <= sh_cnt_q - 1'b1;
          sh_pos_q  <= sh_pos_q + 1'b1;
        end
        // a new nibble lands on the tick that drains the last old bit
        if (take_i) begin
          sh_q     <= nib_i;
          sh_cnt_q <= CW'(NIB_W);
          sh_pos_q <= take_pos_i;
        end
      end
    end
  end

  AST_SH_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sh_cnt_q <= CW'(NIB_W)); // R4
  AST_NIB_DRAINED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nibble_i && take_i |-> sh_cnt_q <= CW'(1)); // R4
  AST_SER_VLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nibble_i && take_i |=> bit_vld_o); // R3

endmodule

// File: rtl/e3_tx_payload_if.sv
module e3_tx_payload_if #(
  parameter int FRAME_BITS = 1536,
  parameter int NIB_W      = 4,
  parameter int POS_W      = $clog2(FRAME_BITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       mode_i,
  input  logic             rec_tick_i,
  input  logic             loc_tick_i,
  input  logic             frame_ref_i,
  input  logic             ser_i,
  input  logic [NIB_W-1:0] nib_i,
  output logic             sys_tick_o,
  output logic             frame_pulse_o,
  output logic             bit_o,
  output logic             bit_vld_o,
  output logic [POS_W-1:0] bit_pos_o
);

  import e3_txp_pkg::*;

  mode_cfg_t        cfg;
  logic             bit_tick, ref_edge, nib_tick, unit_take;
  logic [POS_W-1:0] unit_pos;

  e3_txp_mode_ctrl u_mode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode_i),
    .rec_tick_i  (rec_tick_i),
    .loc_tick_i  (loc_tick_i),
    .frame_ref_i (frame_ref_i),
    .cfg_o       (cfg),
    .bit_tick_o  (bit_tick),
    .ref_edge_o  (ref_edge)
  );

  e3_txp_frame_ctr #(
    .FRAME_BITS (FRAME_BITS),
    .NIB_W      (NIB_W),
    .POS_W      (POS_W)
  ) u_ctr (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .nibble_i      (cfg.nibble),
    .bit_tick_i    (bit_tick),
    .realign_i     (ref_edge),
    .nib_tick_o    (nib_tick),
    .unit_take_o   (unit_take),
    .unit_pos_o    (unit_pos),
    .frame_pulse_o (frame_pulse_o)
  );

  e3_txp_serializer #(
    .NIB_W (NIB_W),
    .POS_W (POS_W)
  ) u_ser (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .nibble_i   (cfg.nibble),
    .bit_tick_i (bit_tick),
    .take_i     (unit_take),
    .take_pos_i (unit_pos),
    .ser_i      (ser_i),
    .nib_i      (nib_i),
    .bit_o      (bit_o),
    .bit_vld_o  (bit_vld_o),
    .bit_pos_o  (bit_pos_o)
  );

  assign sys_tick_o = cfg.nibble ? nib_tick : bit_tick;

  AST_FREE_NO_REALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg.ref_lock |-> !ref_edge); // R8
  AST_NIBCLK_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg.nibble && sys_tick_o |=> !sys_tick_o); // R4
  AST_STREAM_POS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_vld_o |-> bit_pos_o < POS_W'(FRAME_BITS)); // R3

endmodule

// File: tb/e3_tx_payload_if_tb.sv
module e3_tx_payload_if_tb;

  localparam int FRAME = 1536;
  localparam int STEPS = 3400;
  // {mode code, expect nibble, expect loop timing, expect reference lock}
  localparam logic [5:0] VEC [0:6] = '{
    {3'd1, 1'b0, 1'b1, 1'b0},
    {3'd2, 1'b0, 1'b0, 1'b1},
    {3'd3, 1'b0, 1'b0, 1'b0},
    {3'd4, 1'b1, 1'b1, 1'b0},
    {3'd5, 1'b1, 1'b0, 1'b1},
    {3'd6, 1'b1, 1'b0, 1'b0},
    {3'd7, 1'b0, 1'b1, 1'b0}
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [2:0] mode_i = 3'd1;
  logic rec_tick_i = 1'b0, loc_tick_i = 1'b0, frame_ref_i = 1'b0, ser_i = 1'b0;
  logic [3:0] nib_i = '0;
  logic sys_tick_o, frame_pulse_o, bit_o, bit_vld_o;
  logic [10:0] bit_pos_o;

  int n_tests = 0, n_fail = 0;
  logic q_bit [0:4095];
  int   q_pos [0:4095];

  always #2 clk_i = ~clk_i;

  e3_tx_payload_if u_dut (
    .clk_i (clk_i), .rst_ni (rst_ni), .mode_i (mode_i),
    .rec_tick_i (rec_tick_i), .loc_tick_i (loc_tick_i), .frame_ref_i (frame_ref_i),
    .ser_i (ser_i), .nib_i (nib_i), .sys_tick_o (sys_tick_o),
    .frame_pulse_o (frame_pulse_o), .bit_o (bit_o), .bit_vld_o (bit_vld_o),
    .bit_pos_o (bit_pos_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [2:0] md);
    rst_ni = 1'b0; mode_i = md;
    rec_tick_i = 0; loc_tick_i = 0; frame_ref_i = 0;
    repeat (3) @(negedge clk_i);
    chk(bit_vld_o === 1'b0, "R1 reset bit_vld_o", int'(bit_vld_o), 0);
    chk(frame_pulse_o === 1'b0, "R1 reset frame_pulse_o", int'(frame_pulse_o), 0);
    chk(bit_pos_o === '0, "R1 reset bit_pos_o", int'(bit_pos_o), 0);
    rst_ni = 1'b1;
    rec_tick_i = 1; loc_tick_i = 1;  // R9: ticks in capture cycle are dropped
    @(negedge clk_i);
    rec_tick_i = 0; loc_tick_i = 0;
    @(negedge clk_i);
  endtask

  task automatic run_mode(input int row);
    logic [2:0] md;
    bit e_nib, e_loop, e_ref, st_exp, fp_e;
    int exp_unit, ph, wr, rd, err_out, err_fp, err_st, fp_hi, fp_exp;
    logic [15:0] lf;
    md = VEC[row][5:3]; e_nib = VEC[row][2]; e_loop = VEC[row][1]; e_ref = VEC[row][0];
    exp_unit = 0; ph = 0; wr = 0; rd = 0;
    err_out = 0; err_fp = 0; err_st = 0; fp_hi = 0; fp_exp = 0;
    lf = 16'hACE1 ^ 16'(row);
    do_reset(md);
    for (int s = 0; s < STEPS; s++) begin
      @(negedge clk_i);
      if (s == 500) mode_i = md ^ 3'b011;  // R9: late change ignored
      frame_ref_i = 1'b0;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      ser_i = lf[0]; nib_i = lf[3:0];
      rec_tick_i = e_loop; loc_tick_i = !e_loop;
      #1;
      if (!e_nib) begin
        st_exp = 1'b1;
        q_bit[wr] = lf[0]; q_pos[wr] = exp_unit; wr++;
        exp_unit = (exp_unit + 1) % FRAME;
      end else begin
        st_exp = (ph == 3);
        if (st_exp) begin
          for (int k = 0; k < 4; k++) begin
            q_bit[wr] = lf[3-k]; q_pos[wr] = exp_unit + k; wr++;
          end
          exp_unit = (exp_unit + 4) % FRAME;
        end
        ph = (ph + 1) % 4;
      end
      if (sys_tick_o !== st_exp) err_st++;
      @(negedge clk_i);
      rec_tick_i = !e_loop; loc_tick_i = e_loop;  // R2: unused line pulses
      #1;
      if (sys_tick_o !== 1'b0) err_st++;
      if (bit_vld_o) begin
        if (rd >= wr || bit_o !== q_bit[rd] || int'(bit_pos_o) != q_pos[rd]) err_out++;
        rd++;
      end
      fp_e = (exp_unit == (e_nib ? FRAME - 4 : FRAME - 1));
      if (frame_pulse_o !== fp_e) err_fp++;
      fp_hi += int'(frame_pulse_o); fp_exp += int'(fp_e);
      if (s == 1000) begin
        frame_ref_i = 1'b1;
        if (e_ref) begin exp_unit = 0; ph = 0; end
      end
    end
    @(negedge clk_i);
    rec_tick_i = 0; loc_tick_i = 0; frame_ref_i = 0;
    $display("[TB] mode %0d row %0d done", md, row);
    if (e_nib) chk(err_out == 0, "R4 nibble bit order and positions", err_out, 0);
    else       chk(err_out == 0, "R3 serial stream and positions", err_out, 0);
    if (e_nib) chk(err_st == 0, "R4 nibble clock on sys_tick_o", err_st, 0);
    else       chk(err_st == 0, "R5 serial sys_tick_o", err_st, 0);
    chk(rd <= wr && rd >= wr - 4, "R2 timing source drives stream", rd, wr);
    chk(err_fp == 0, "R6 frame pulse placement", err_fp, 0);
    chk(fp_hi == fp_exp && fp_exp > 0, "R6 frame pulse count", fp_hi, fp_exp);
    if (e_ref) chk(err_fp == 0 && err_out == 0, "R7 realign to reference", err_fp + err_out, 0);
    else       chk(err_fp == 0 && err_out == 0, "R8 reference ignored", err_fp + err_out, 0);
    chk(err_out == 0 && err_fp == 0, "R9 mode held after capture", err_out + err_fp, 0);
  endtask

  initial begin
    for (int r = 0; r < 7; r++) run_mode(r);
    // directed: serial, first tick after reset lands at position 0 (R9)
    do_reset(3'd3);
    @(negedge clk_i); loc_tick_i = 1; ser_i = 1;
    @(negedge clk_i); loc_tick_i = 0;
    #1;
    chk(bit_vld_o === 1'b1 && bit_pos_o === '0 && bit_o === 1'b1,
        "R9 first counted tick is position 0", int'(bit_pos_o), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule